// File: doc/BRIEF.md
# CAN Interrupt Identifier and Status Unit

This block keeps the interrupt bookkeeping of a CAN controller. It holds four status flags: transmit-ok, receive-ok, error-warning and bus-off. It collects interrupt requests from two kinds of source. One is a status-change source, raised when one of those flags changes. The others are a set of message objects, each with its own pending bit. The block reports the most urgent pending source as a numeric identifier. It drives one interrupt line to the CPU, and a control enable bit gates that line.

The protocol engine supplies single-cycle pulses for a completed transmission and a completed reception. It also supplies the current transmit and receive error counter values, a bus-off level, and one event pulse per message object. The CPU reaches the block over a 16-bit register bus addressed by word. The bus has read and write strobes, two byte enables, and read data registered one cycle after the read strobe.

The register layout is as follows.
- **Word 0, low byte (control):** bit 0 enables the interrupt line and bit 1 enables status-change interrupts.
- **Word 0, high byte (status):** bit 8 is transmit-ok, bit 9 is receive-ok, bit 10 is error-warning and bit 11 is bus-off.
- **Word 1:** carries the identifier in its low byte.
- **Word 2 onward:** holds the message-object pending bits, 16 per word, with object 0 in bit 0 of word 2.

Top module: `can_irq_unit`

## Requirements
- R1: After reset, the identifier is 00h, the interrupt line is low, and every control bit, status flag and pending bit reads 0.
- R2: The identifier is 00h when nothing is pending. It is 01h for a pending status change and 02h+i for pending message object i. It updates on the second rising edge after the causing input or bus access.
- R3: The pending source with the lowest code wins. A lower-code source that becomes pending replaces the current identifier, and clearing the winner exposes the next pending source.
- R4: The interrupt line is high exactly when the enable bit (word 0 bit 0) was set and the identifier is nonzero. It follows the identifier with the same latency.
- R5: Clearing the enable bit drops the interrupt line while sources remain pending. The line also drops once the identifier returns to 00h.
- R6: A transmit-done pulse sets transmit-ok (bit 8) and a receive-done pulse sets receive-ok (bit 9). Only a CPU write to word 0 with the high byte enabled and a 0 in that bit clears either flag. Writing 1 keeps the flag.
- R7: Error-warning (bit 10) is 1 while either error counter is at or above the limit (default 96). It is 0 once both counters are below the limit.
- R8: Bus-off (bit 11) follows the bus-off input.
- R9: When status-change enable (word 0 bit 1) is set, a status change becomes pending on any hardware-caused change of the four flags. A transmit-ok or receive-ok 0-to-1 transition counts, as does any toggle of error-warning or bus-off. When the enable is clear, no status change becomes pending.
- R10: A read of word 0 with the high-byte enable set clears a pending status change. A read with only the low-byte enable leaves it pending.
- R11: A message-object event sets that object's pending bit. A write to its pending word with a 1 in its bit, under the matching byte enable, clears it. Zeros and disabled bytes leave the bit unchanged.
- R12: A read of word 0, 1 or 2 returns the layout above, with unused bits 0, in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_be | input | 2 | Byte enables (bit 0 low byte, bit 1 high byte) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| tx_done | input | 1 | Pulse: transmission completed and acknowledged |
| rx_done | input | 1 | Pulse: reception completed |
| tec | input | CNT_W | Transmit error counter value |
| rec | input | CNT_W | Receive error counter value |
| boff_in | input | 1 | Controller is in bus-off state |
| obj_evt | input | NUM_OBJ | Per-object interrupt event pulses |
| int_id | output | ID_W | Identifier of the winning pending source |
| irq | output | 1 | Interrupt line to the CPU |

## Verification
Directed sequences first cover the priority cases:
- **Preemption:** a high-numbered object is pending when a lower-numbered object arrives, and then a status change arrives on top.
- **Unwinding:** each winner is then cleared in turn. This separates lowest-code selection from last-arrival selection.

Corner cases are checked next:
- **Error limit:** the counters are set one below the limit and then exactly at it, which catches an off-by-one in the comparison.
- **Byte-enable reads:** word 0 is read with the low byte only and then with the high byte. This shows whether the clear side effect is tied to the correct byte enable.
- **Enable gating:** the line enable and the status-change enable are each switched off, which separates gating of the line from suppression of the request.

A long seeded random mix then interleaves events, counter moves, clears and reads of every word. Each step is compared against a bench model of flags and pending bits. This exposes sticky-flag and priority errors that only appear under overlapping sources.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

  localparam int WORD_W = 16;

  // Register word addresses
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_ID   = 1;
  localparam int ADDR_OBJ  = 2;

  // Bit positions inside word 0
  localparam int CTRL_IE_BIT  = 0;
  localparam int CTRL_SIE_BIT = 1;
  localparam int STAT_TX_BIT  = 8;
  localparam int STAT_RX_BIT  = 9;

  typedef struct packed {
    logic boff;
    logic ewrn;
    logic rxok;
    logic txok;
  } stat_t;

endpackage

// File: rtl/can_irq_stat.sv
module can_irq_stat #(
  parameter int CNT_W      = 8,
  parameter int EWRN_LIMIT = 96
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_done,
  input  logic             rx_done,
  input  logic [CNT_W-1:0] tec,
  input  logic [CNT_W-1:0] rec,
  input  logic             boff_in,
  input  logic             sc_en,
  input  logic             clr_tx,
  input  logic             clr_rx,
  input  logic             sc_clr,
  output can_irq_pkg::stat_t stat,
  output logic             sc_pend
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(EWRN_LIMIT);

  logic ewrn_d;
  logic tx_rise, rx_rise, changed;

  assign ewrn_d  = (tec >= LIMIT) || (rec >= LIMIT);
  assign tx_rise = tx_done && !stat.txok;
  assign rx_rise = rx_done && !stat.rxok;
  assign changed = tx_rise || rx_rise ||
                   (ewrn_d != stat.ewrn) || (boff_in != stat.boff);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat    <= '0;
      sc_pend <= 1'b0;
    end else begin
      // hardware sets win over a CPU clear in the same cycle
      if (tx_done)     stat.txok <= 1'b1;
      else if (clr_tx) stat.txok <= 1'b0;
      if (rx_done)     stat.rxok <= 1'b1;
      else if (clr_rx) stat.rxok <= 1'b0;
      stat.ewrn <= ewrn_d;
      stat.boff <= boff_in;
      if (sc_en && changed) sc_pend <= 1'b1;
      else if (sc_clr)      sc_pend <= 1'b0;
    end
  end

endmodule

// File: rtl/can_irq_objpend.sv
module can_irq_objpend #(
  parameter int NUM_OBJ = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OBJ-1:0] evt,
  input  logic [NUM_OBJ-1:0] clr,
  output logic [NUM_OBJ-1:0] pend
);

  for (genvar gi = 0; gi < NUM_OBJ; gi++) begin : g_obj
    always_ff @(posedge clk) begin
      if (rst)          pend[gi] <= 1'b0;
      else if (evt[gi]) pend[gi] <= 1'b1;
      else if (clr[gi]) pend[gi] <= 1'b0;
    end
  end

endmodule

// File: rtl/can_irq_prio.sv
module can_irq_prio #(
  parameter int NUM_OBJ = 14,
  parameter int ID_W    = 8
) (
  input  logic               sc_pend,
  input  logic [NUM_OBJ-1:0] obj_pend,
  output logic [ID_W-1:0]    id
);

  // Scan from the highest object down so the lowest pending index remains.
  always_comb begin
    id = '0;
    for (int i = NUM_OBJ - 1; i >= 0; i--) begin
      if (obj_pend[i]) id = ID_W'(i + 2);
    end
    if (sc_pend) id = ID_W'(1);
  end

endmodule

// File: rtl/can_irq_unit.sv
module can_irq_unit
  import can_irq_pkg::*;
#(
  parameter int NUM_OBJ    = 14,
  parameter int CNT_W      = 8,
  parameter int EWRN_LIMIT = 96,
  parameter int ADDR_W     = 4,
  parameter int ID_W       = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [1:0]         bus_be,
  input  logic [15:0]        bus_wdata,
  output logic [15:0]        bus_rdata,
  input  logic               tx_done,
  input  logic               rx_done,
  input  logic [CNT_W-1:0]   tec,
  input  logic [CNT_W-1:0]   rec,
  input  logic               boff_in,
  input  logic [NUM_OBJ-1:0] obj_evt,
  output logic [ID_W-1:0]    int_id,
  output logic               irq
);

  localparam int OBJ_WORDS = (NUM_OBJ + WORD_W - 1) / WORD_W;
  localparam int PAD_W     = OBJ_WORDS * WORD_W;

  logic               ctrl_ie, ctrl_sie;
  stat_t              stat;
  logic               sc_pend;
  logic [NUM_OBJ-1:0] obj_pend, obj_clr;
  logic [ID_W-1:0]    id_comb, int_id_q;
  logic               irq_q;
  logic [15:0]        rdata_q, rd_word;
  logic [PAD_W-1:0]   obj_pad;
  logic               ctrl_wr, ctrl_rd;
  logic               clr_tx, clr_rx, sc_clr;
  logic               unused_wbits;

  assign unused_wbits = ^bus_wdata;

  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));
  assign ctrl_rd = bus_rd && (bus_addr == ADDR_W'(ADDR_CTRL));
  assign clr_tx  = ctrl_wr && bus_be[1] && !bus_wdata[STAT_TX_BIT];
  assign clr_rx  = ctrl_wr && bus_be[1] && !bus_wdata[STAT_RX_BIT];
  assign sc_clr  = ctrl_rd && bus_be[1];

  // control byte
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_ie  <= 1'b0;
      ctrl_sie <= 1'b0;
    end else if (ctrl_wr && bus_be[0]) begin
      ctrl_ie  <= bus_wdata[CTRL_IE_BIT];
      ctrl_sie <= bus_wdata[CTRL_SIE_BIT];
    end
  end

  can_irq_stat #(
    .CNT_W     (CNT_W),
    .EWRN_LIMIT(EWRN_LIMIT)
  ) stat_i (
    .clk    (clk),
    .rst    (rst),
    .tx_done(tx_done),
    .rx_done(rx_done),
    .tec    (tec),
    .rec    (rec),
    .boff_in(boff_in),
    .sc_en  (ctrl_sie),
    .clr_tx (clr_tx),
    .clr_rx (clr_rx),
    .sc_clr (sc_clr),
    .stat   (stat),
    .sc_pend(sc_pend)
  );

  // per-object write-one-to-clear strobes
  for (genvar gi = 0; gi < NUM_OBJ; gi++) begin : g_clr
    localparam int WI = gi / WORD_W;
    localparam int BI = gi % WORD_W;
    assign obj_clr[gi] = bus_wr && (bus_addr == ADDR_W'(ADDR_OBJ + WI)) &&
                         bus_be[BI / 8] && bus_wdata[BI];
  end

  can_irq_objpend #(
    .NUM_OBJ(NUM_OBJ)
  ) objpend_i (
    .clk (clk),
    .rst (rst),
    .evt (obj_evt),
    .clr (obj_clr),
    .pend(obj_pend)
  );

  can_irq_prio #(
    .NUM_OBJ(NUM_OBJ),
    .ID_W   (ID_W)
  ) prio_i (
    .sc_pend (sc_pend),
    .obj_pend(obj_pend),
    .id      (id_comb)
  );

  // read mux
  always_comb begin
    obj_pad = '0;
    obj_pad[NUM_OBJ-1:0] = obj_pend;
    rd_word = '0;
    if (bus_addr == ADDR_W'(ADDR_CTRL)) begin
      rd_word = {4'b0, stat, 6'b0, ctrl_sie, ctrl_ie};
    end else if (bus_addr == ADDR_W'(ADDR_ID)) begin
      rd_word = 16'(int_id_q);
    end else begin
      for (int w = 0; w < OBJ_WORDS; w++) begin
        if (bus_addr == ADDR_W'(ADDR_OBJ + w)) rd_word = obj_pad[w*WORD_W +: WORD_W];
      end
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      int_id_q <= '0;
      irq_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      int_id_q <= id_comb;
      irq_q    <= ctrl_ie && (id_comb != '0);
      if (bus_rd) rdata_q <= rd_word;
    end
  end

  assign int_id    = int_id_q;
  assign irq       = irq_q;
  assign bus_rdata = rdata_q;

endmodule

// File: rtl/can_irq_unit_chk.sv
module can_irq_unit_chk #(
  parameter int NUM_OBJ    = 14,
  parameter int CNT_W      = 8,
  parameter int EWRN_LIMIT = 96,
  parameter int ADDR_W     = 4,
  parameter int ID_W       = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [1:0]         bus_be,
  input logic [15:0]        bus_wdata,
  input logic [CNT_W-1:0]   tec,
  input logic [CNT_W-1:0]   rec,
  input logic               boff_in,
  input logic [ID_W-1:0]    int_id,
  input logic               irq,
  input logic               ie,
  input logic               sc_pend,
  input logic [NUM_OBJ-1:0] obj_pend,
  input logic               txok,
  input logic               ewrn,
  input logic               boff
);

  localparam logic [CNT_W-1:0] LIM = CNT_W'(EWRN_LIMIT);

  AST_IRQ_HAS_ID: assert property (@(posedge clk) disable iff (rst)
    irq |-> (int_id != '0)); // R4

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ie)); // R4

  AST_EN_OFF_DROPS: assert property (@(posedge clk) disable iff (rst)
    !ie |=> !irq); // R5

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!sc_pend && (obj_pend == '0)) |=> (int_id == '0)); // R2

  AST_SC_WINS: assert property (@(posedge clk) disable iff (rst)
    sc_pend |=> (int_id == ID_W'(1))); // R3

  AST_TX_STICKY: assert property (@(posedge clk) disable iff (rst)
    (txok && !(bus_wr && bus_addr == '0 && bus_be[1] && !bus_wdata[8])) |=> txok); // R6

  AST_EWRN_SET: assert property (@(posedge clk) disable iff (rst)
    ((tec >= LIM) || (rec >= LIM)) |=> ewrn); // R7

  AST_BOFF_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    boff_in |=> boff); // R8

  AST_LOWREAD_KEEP: assert property (@(posedge clk) disable iff (rst)
    (sc_pend && bus_rd && !bus_wr && bus_addr == '0 && bus_be == 2'b01) |=> sc_pend); // R10

endmodule

bind can_irq_unit can_irq_unit_chk #(
  .NUM_OBJ   (NUM_OBJ),
  .CNT_W     (CNT_W),
  .EWRN_LIMIT(EWRN_LIMIT),
  .ADDR_W    (ADDR_W),
  .ID_W      (ID_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_be   (bus_be),
  .bus_wdata(bus_wdata),
  .tec      (tec),
  .rec      (rec),
  .boff_in  (boff_in),
  .int_id   (int_id),
  .irq      (irq),
  .ie       (ctrl_ie),
  .sc_pend  (sc_pend),
  .obj_pend (obj_pend),
  .txok     (stat.txok),
  .ewrn     (stat.ewrn),
  .boff     (stat.boff)
);

// File: tb/can_irq_unit_tb.sv
module can_irq_unit_tb_top;

  localparam int CLK_P   = 10;
  localparam int NOBJ    = 14;
  localparam int CW      = 8;
  localparam int LIMIT   = 96;
  localparam int AW      = 4;
  localparam int IW      = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [AW-1:0]   bus_addr = '0;
  logic            bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]      bus_be = '0;
  logic [15:0]     bus_wdata = '0;
  logic [15:0]     bus_rdata;
  logic            tx_done = 1'b0, rx_done = 1'b0;
  logic [CW-1:0]   tec = '0, rec = '0;
  logic            boff_in = 1'b0;
  logic [NOBJ-1:0] obj_evt = '0;
  logic [IW-1:0]   int_id;
  logic            irq;

  always #(CLK_P/2) clk = ~clk;

  can_irq_unit #(
    .NUM_OBJ(NOBJ), .CNT_W(CW), .EWRN_LIMIT(LIMIT), .ADDR_W(AW), .ID_W(IW)
  ) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_done(tx_done), .rx_done(rx_done), .tec(tec), .rec(rec), .boff_in(boff_in),
    .obj_evt(obj_evt), .int_id(int_id), .irq(irq)
  );

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;

  // bench model
  bit m_ie, m_sie, m_tx, m_rx, m_ew, m_bo, m_sc;
  bit [NOBJ-1:0] m_obj;

  function automatic int exp_id();
    if (m_sc) return 1;
    for (int i = 0; i < NOBJ; i++) if (m_obj[i]) return i + 2;
    return 0;
  endfunction

  function automatic logic [15:0] exp_w0();
    return {4'b0, m_bo, m_ew, m_rx, m_tx, 6'b0, m_sie, m_ie};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_out(string tag);
    chk({tag, " id"}, 32'(int_id), 32'(exp_id()));
    chk({tag, " irq"}, 32'(irq), 32'(m_ie && exp_id() != 0));
  endtask

  task automatic hw_change(bit was, bit now);
    if (was != now && m_sie) m_sc = 1;
  endtask

  // one bus access, then settle so the identifier reflects it
  task automatic bus_op(bit wr, bit rd, int addr, logic [1:0] be, logic [15:0] wd,
                        output logic [15:0] rdv);
    bus_wr = wr; bus_rd = rd; bus_addr = AW'(addr); bus_be = be; bus_wdata = wd;
    @(negedge clk);
    rdv = bus_rdata;
    bus_wr = 0; bus_rd = 0; bus_be = '0;
    @(negedge clk);
  endtask

  task automatic wr_ctrl(bit ie, bit sie, string tag);
    logic [15:0] r;
    bus_op(1, 0, 0, 2'b01, {14'b0, sie, ie}, r);
    m_ie = ie; m_sie = sie;
    check_out(tag);
  endtask

  task automatic wr_stat(bit tx, bit rx, string tag);
    logic [15:0] r;
    bus_op(1, 0, 0, 2'b10, {6'b0, rx, tx, 8'b0}, r);
    m_tx = m_tx & tx; m_rx = m_rx & rx;
    check_out(tag);
  endtask

  task automatic rd_ctrl(logic [1:0] be, string tag);
    logic [15:0] r;
    logic [15:0] e;
    e = exp_w0();
    bus_op(0, 1, 0, be, 16'h0, r);
    chk({tag, " word0"}, 32'(r), 32'(e));
    if (be[1]) m_sc = 0;
    check_out(tag);
  endtask

  task automatic rd_id(string tag);
    logic [15:0] r;
    logic [15:0] e;
    e = 16'(exp_id());
    bus_op(0, 1, 1, 2'b11, 16'h0, r);
    chk({tag, " word1"}, 32'(r), 32'(e));
    check_out(tag);
  endtask

  task automatic rd_obj(string tag);
    logic [15:0] r;
    logic [15:0] e;
    e = 16'(m_obj);
    bus_op(0, 1, 2, 2'b11, 16'h0, r);
    chk({tag, " word2"}, 32'(r), 32'(e));
    check_out(tag);
  endtask

  task automatic clr_obj(logic [15:0] mask, logic [1:0] be, string tag);
    logic [15:0] r;
    logic [15:0] m;
    bus_op(1, 0, 2, be, mask, r);
    m = mask & {{8{be[1]}}, {8{be[0]}}};
    m_obj = m_obj & ~m[NOBJ-1:0];
    check_out(tag);
  endtask

  task automatic obj_pulse(int i, string tag);
    obj_evt = '0; obj_evt[i] = 1'b1;
    @(negedge clk);
    obj_evt = '0;
    m_obj[i] = 1;
    @(negedge clk);
    check_out(tag);
  endtask

  task automatic tx_pulse(bit is_rx, string tag);
    if (is_rx) rx_done = 1; else tx_done = 1;
    @(negedge clk);
    tx_done = 0; rx_done = 0;
    if (is_rx) begin hw_change(m_rx, 1); m_rx = 1; end
    else       begin hw_change(m_tx, 1); m_tx = 1; end
    @(negedge clk);
    check_out(tag);
  endtask

  task automatic set_cnt(int t, int r, string tag);
    bit ew;
    tec = CW'(t); rec = CW'(r);
    @(negedge clk);
    ew = (t >= LIMIT) || (r >= LIMIT);
    hw_change(m_ew, ew); m_ew = ew;
    @(negedge clk);
    check_out(tag);
  endtask

  task automatic set_boff(bit b, string tag);
    boff_in = b;
    @(negedge clk);
    hw_change(m_bo, b); m_bo = b;
    @(negedge clk);
    check_out(tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C4A));
    m_ie = 0; m_sie = 0; m_tx = 0; m_rx = 0; m_ew = 0; m_bo = 0; m_sc = 0; m_obj = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    check_out("R1 reset");
    rd_ctrl(2'b11, "R1 reset");
    rd_obj("R1 reset");

    // R2/R3 priority and preemption
    wr_ctrl(1, 1, "R4 enable");
    obj_pulse(9, "R2 obj9");
    rd_id("R12 id read");
    obj_pulse(2, "R3 preempt obj2");
    obj_pulse(11, "R3 lower prio kept");
    tx_pulse(0, "R9 tx status change");
    rd_ctrl(2'b01, "R10 low-byte read keeps");
    chk("R10 still pending", 32'(int_id), 32'd1);
    rd_ctrl(2'b10, "R10 high read clears");
    chk("R3 next source", 32'(int_id), 32'd4);
    clr_obj(16'h0004, 2'b10, "R11 disabled byte ignored");
    chk("R11 kept", 32'(int_id), 32'd4);
    clr_obj(16'h0004, 2'b01, "R11 clear obj2");
    chk("R3 unwind to obj9", 32'(int_id), 32'd11);
    rd_obj("R11 pending word");

    // R5 enable gating
    wr_ctrl(0, 1, "R5 disable line");
    chk("R5 line low", 32'(irq), 32'd0);
    wr_ctrl(1, 1, "R5 re-enable");
    clr_obj(16'h0A00, 2'b11, "R5 clear all");
    chk("R5 idle id", 32'(int_id), 32'd0);
    chk("R5 idle line", 32'(irq), 32'd0);

    // R6 sticky flags
    tx_pulse(1, "R6 rx set");
    rd_ctrl(2'b11, "R6 flags");
    tx_pulse(0, "R6 tx again no change");
    wr_stat(1, 1, "R6 write one keeps");
    rd_ctrl(2'b11, "R6 kept");
    wr_stat(0, 1, "R6 clear tx");
    rd_ctrl(2'b11, "R6 tx cleared");

    // R7 limit boundary
    set_cnt(LIMIT - 1, 0, "R7 below limit");
    rd_ctrl(2'b11, "R7 no warning");
    set_cnt(0, LIMIT, "R7 rec at limit");
    rd_ctrl(2'b11, "R7 warning");
    set_cnt(LIMIT, LIMIT - 1, "R7 tec at limit");
    set_cnt(10, 20, "R7 warning off");
    rd_ctrl(2'b11, "R7 cleared");

    // R8 bus-off, R9 with enable off
    set_boff(1, "R8 boff on");
    rd_ctrl(2'b11, "R8 word0");
    wr_ctrl(1, 0, "R9 sie off");
    set_boff(0, "R9 no status change");
    chk("R9 no sc", 32'(int_id), 32'd0);
    rd_ctrl(2'b11, "R8 boff off");

    // random mix
    for (int it = 0; it < 1500; it++) begin
      case ($urandom_range(0, 11))
        0: tx_pulse(0, "R6 rnd tx");
        1: tx_pulse(1, "R6 rnd rx");
        2: set_cnt(88 + $urandom_range(0, 16), 88 + $urandom_range(0, 16), "R7 rnd cnt");
        3: set_boff(1'($urandom_range(0, 1)), "R8 rnd boff");
        4, 5: obj_pulse($urandom_range(0, NOBJ - 1), "R3 rnd obj");
        6: clr_obj(16'($urandom), 2'($urandom_range(0, 3)), "R11 rnd clr");
        7: wr_ctrl(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0), "R5 rnd ctrl");
        8: wr_stat(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R6 rnd wstat");
        9: rd_ctrl(2'($urandom_range(1, 3)), "R10 rnd rd");
        10: rd_id("R12 rnd id");
        default: rd_obj("R12 rnd obj");
      endcase
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule